// File: doc/BRIEF.md
# Preemptive Priority Interrupt Arbiter

This block chooses which of eight interrupt sources a processor services next. It keeps one pending bit per source and one mask bit per source. It also keeps the priority level the processor is working on now. A pulse on a request line latches that source as pending. The arbiter picks the best pending source that is not masked, where a smaller index means a more urgent source. It grants that source when the processor is idle. It also grants it when the source is strictly more urgent than the level being serviced.

On a preempting grant, the interrupted level is pushed onto an internal stack. An end-of-service pulse from the handler pops that stack, which returns the arbiter to the interrupted level, or to idle when nothing was interrupted. The current level is always visible on the ports. Idle has its own code, NUM_SRC (8), which no valid level uses.

Top module: `prio_preempt_arb`

## Requirements
- R1: After reset, `level_o` is 8, the idle code, and `grant_o` is 0. `level_o` never exceeds 8, and the values 0 to 7 name the level being serviced.
- R2: Among eligible pending sources, the one with the smallest index wins. Index 0 is the most urgent.
- R3: When a request is sampled at clock edge E, its pending bit is set at E. If the arbiter is idle, the grant appears at edge E+1, and `level_o` becomes the granted index at that same edge.
- R4: While level k is being serviced, a pending source with an index greater than k produces no grant and leaves `level_o` at k.
- R5: While level k is being serviced, a pending source h with h < k is granted, and `level_o` becomes h. A grant is never given to an index that is equal to or greater than the level in force before the grant edge.
- R6: A request whose index equals the level in service does not preempt it. It stays pending and is granted once the level changes to a less urgent value or to idle.
- R7: `mask_i` is loaded on an edge where `mask_we_i` is 1. A mask bit of 1 keeps that source from being granted, but its pending bit is kept. A new mask value first takes part in the decision on the edge after it is loaded.
- R8: `grant_o` is high for one cycle per grant, with `grant_idx_o` holding the index. The grant clears that pending bit, unless a new request for the same source is sampled on the grant edge, in which case the bit stays set.
- R9: A preempting grant saves the interrupted level. An `eos_i` pulse restores the most recently saved level, or idle when none is saved. Nesting through all eight levels (7 down to 0) unwinds in reverse order.
- R10: `eos_i` while idle has no effect. On an edge where `eos_i` is sampled high, no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 8 | Request pulses, one bit per source |
| mask_we_i | input | 1 | Load strobe for the mask register |
| mask_i | input | 8 | New mask value; 1 disables that source |
| eos_i | input | 1 | End-of-service pulse from the running handler |
| grant_o | output | 1 | One-cycle grant pulse |
| grant_idx_o | output | 3 | Index of the granted source, valid while `grant_o` is 1 |
| level_o | output | 4 | Level in service; 8 means idle |

## Verification
A wrong level register shows on `level_o` within one cycle. It also shows in the next grant decision: a wrong level either withholds a grant that is due or lets through a preemption that should be refused. A corrupted save stack stays hidden until the matching end-of-service pulse. At that point `level_o` returns to a wrong level or goes idle too early. The bench therefore unwinds nested preemptions all the way back to idle. A pending bit that is left set, or cleared too early, shows up as an extra grant or a missing grant after the next level change. Every sweep is drained through end-of-service pulses so that such a fault reaches the ports.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_GRANT = 2'd1,
    ACT_POP   = 2'd2
  } arb_act_e;
endpackage

// File: rtl/arb_pend.sv
module arb_pend #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_sn,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               clr_en_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] elig_o
);
  logic [NUM_SRC-1:0] pend_q, pend_d;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] clr_vec;

  // a fresh request wins over the clear of the same bit
  always_comb begin
    clr_vec = clr_en_i ? (NUM_SRC'(1) << clr_idx_i) : '0;
    pend_d  = (pend_q & ~clr_vec) | req_i;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_i;
  end

  assign elig_o = pend_q & ~mask_q;

  // R7: a masked source is never selected for clearing
  a_r7_masked_not_taken: assert property (@(posedge clk) disable iff (!rst_sn)
    clr_en_i |-> !mask_q[clr_idx_i]);

  // R8: the granted bit holds exactly the re-request of the grant edge
  a_r8_clear_or_reset: assert property (@(posedge clk) disable iff (!rst_sn)
    clr_en_i |=> (pend_q[$past(clr_idx_i)] == $past(req_i[clr_idx_i])));
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] vec_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/arb_stack.sv
module arb_stack #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] top_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [SP_W-1:0]  sp_q, sp_d;
  logic [SP_W-1:0]  sp_m1;

  always_comb begin
    sp_m1 = sp_q - SP_W'(1);
    sp_d  = sp_q;
    if (push_i)     sp_d = sp_q + SP_W'(1);
    else if (pop_i) sp_d = sp_m1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) sp_q <= '0;
    else         sp_q <= sp_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)                                       mem_q[g] <= '0;
      else if (push_i && (sp_q[PTR_W-1:0] == PTR_W'(g))) mem_q[g] <= din_i;
    end
  end

  assign top_o   = mem_q[sp_m1[PTR_W-1:0]];
  assign empty_o = (sp_q == '0);

  // R9: strict preemption keeps the nesting within the depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_sn)
    push_i |-> (sp_q != SP_W'(DEPTH)));
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_sn)
    pop_i |-> (sp_q != '0));
  a_r9_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_sn)
    !(push_i && pop_i));
endmodule

// File: rtl/prio_preempt_arb.sv
module prio_preempt_arb #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = $clog2(NUM_SRC),
  localparam int LVL_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               eos_i,
  output logic               grant_o,
  output logic [IDX_W-1:0]   grant_idx_o,
  output logic [LVL_W-1:0]   level_o
);
  import arb_pkg::*;

  localparam logic [LVL_W-1:0] IDLE = LVL_W'(NUM_SRC);

  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  logic [NUM_SRC-1:0] elig;
  logic               pick_any;
  logic [IDX_W-1:0]   pick_idx;
  logic [LVL_W-1:0]   lvl_q, lvl_d;
  logic               grant_q, grant_d;
  logic [IDX_W-1:0]   gidx_q;
  logic               stk_empty;
  logic [LVL_W-1:0]   stk_top;
  logic               busy, push, pop;
  arb_act_e           act;

  arb_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .req_i     (req_i),
    .clr_en_i  (grant_d),
    .clr_idx_i (pick_idx),
    .mask_we_i (mask_we_i),
    .mask_i    (mask_i),
    .elig_o    (elig)
  );

  arb_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .vec_i (elig),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  arb_stack #(.DEPTH(NUM_SRC), .WIDTH(LVL_W)) u_stack (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   (lvl_q),
    .top_o   (stk_top),
    .empty_o (stk_empty)
  );

  // idle code exceeds every index, so one compare covers idle and busy
  always_comb begin
    busy = (lvl_q != IDLE);
    act  = ACT_HOLD;
    if (eos_i) begin
      if (busy) act = ACT_POP;
    end else if (pick_any && ({1'b0, pick_idx} < lvl_q)) begin
      act = ACT_GRANT;
    end
    grant_d = (act == ACT_GRANT);
    push    = grant_d && busy;
    pop     = (act == ACT_POP) && !stk_empty;
    case (act)
      ACT_GRANT: lvl_d = {1'b0, pick_idx};
      ACT_POP:   lvl_d = stk_empty ? IDLE : stk_top;
      default:   lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      lvl_q   <= IDLE;
      grant_q <= 1'b0;
      gidx_q  <= '0;
    end else begin
      lvl_q   <= lvl_d;
      grant_q <= grant_d;
      if (grant_d) gidx_q <= pick_idx;
    end
  end

  assign grant_o     = grant_q;
  assign grant_idx_o = gidx_q;
  assign level_o     = lvl_q;

  a_r1_level_range: assert property (@(posedge clk) disable iff (!rst_sn)
    lvl_q <= IDLE);
  a_r5_strict_preempt: assert property (@(posedge clk) disable iff (!rst_sn)
    grant_o |-> ({1'b0, grant_idx_o} < $past(lvl_q)));
  a_r10_no_grant_on_eos: assert property (@(posedge clk) disable iff (!rst_sn)
    eos_i |=> !grant_o);
  a_r3_grant_sets_level: assert property (@(posedge clk) disable iff (!rst_sn)
    grant_o |-> (level_o == {1'b0, grant_idx_o}));
endmodule

// File: tb/prio_preempt_arb_tb.sv
`timescale 1ns/1ps
module prio_preempt_arb_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_i = '0;
  logic       mask_we_i = 1'b0;
  logic [7:0] mask_i = '0;
  logic       eos_i = 1'b0;
  logic       grant_o;
  logic [2:0] grant_idx_o;
  logic [3:0] level_o;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_en = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_preempt_arb dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_we_i(mask_we_i),
    .mask_i(mask_i), .eos_i(eos_i), .grant_o(grant_o),
    .grant_idx_o(grant_idx_o), .level_o(level_o)
  );

  // behavioural expectation built from the requirements
  logic [7:0] m_pend, m_mask;
  int m_lvl, m_sp, m_gnt, m_idx;
  int m_stk [8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_mask = '0; m_lvl = 8; m_sp = 0; m_gnt = 0; m_idx = 0;
    end else begin
      int h;
      h = -1;
      for (int i = 7; i >= 0; i--) if (m_pend[i] && !m_mask[i]) h = i;
      m_gnt = 0;
      if (eos_i) begin
        if (m_lvl != 8) begin
          if (m_sp > 0) begin m_sp--; m_lvl = m_stk[m_sp]; end
          else m_lvl = 8;
        end
      end else if (h >= 0 && h < m_lvl) begin
        if (m_lvl != 8) begin m_stk[m_sp] = m_lvl; m_sp++; end
        m_lvl = h; m_gnt = 1; m_idx = h; m_pend[h] = 1'b0;
      end
      m_pend = m_pend | req_i;
      if (mask_we_i) m_mask = mask_i;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(grant_o == m_gnt[0], m_gnt ? "R3 grant" : "R4 no grant", grant_o, m_gnt);
      if (m_gnt != 0) chk(grant_idx_o == m_idx[2:0], "R2 index", grant_idx_o, m_idx);
      chk(level_o == m_lvl[3:0], "R9 level", level_o, m_lvl);
    end
  end

  task automatic tick; @(posedge clk); #1; endtask
  task automatic pulse_req(logic [7:0] v); req_i = v; tick(); req_i = '0; endtask
  task automatic pulse_eos; eos_i = 1'b1; tick(); eos_i = 1'b0; endtask
  task automatic set_mask(logic [7:0] v);
    mask_we_i = 1'b1; mask_i = v; tick(); mask_we_i = 1'b0;
  endtask
  task automatic drain;
    for (int n = 0; n < 100; n++) begin
      if (m_lvl == 8 && (m_pend & ~m_mask) == 0) break;
      if (m_lvl != 8) pulse_eos(); else tick();
    end
    tick();
  endtask
  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk(level_o == 4'd8, "R1 idle after reset", level_o, 8);
    chk(grant_o == 1'b0, "R1 no grant after reset", grant_o, 0);
    cmp_en = 1;

    // R2 R3: lowest index wins from idle
    pulse_req(8'b1010_0100); tick();
    chk(grant_o && grant_idx_o == 3'd2, "R3 idle grant", grant_idx_o, 2);
    chk(level_o == 4'd2, "R3 level set", level_o, 2);
    tick();
    chk(!grant_o && level_o == 4'd2, "R4 lower waits", level_o, 2);
    // R6: equal level re-request does not preempt
    pulse_req(8'b0000_0100); tick(); tick();
    chk(!grant_o && level_o == 4'd2, "R6 equal no preempt", level_o, 2);
    pulse_eos();
    chk(level_o == 4'd8 && !grant_o, "R10 eos edge no grant", level_o, 8);
    tick();
    chk(grant_o && grant_idx_o == 3'd2, "R6 granted after level change", grant_idx_o, 2);
    pulse_eos(); tick();
    chk(grant_o && grant_idx_o == 3'd5, "R2 next pending", grant_idx_o, 5);
    pulse_eos(); tick();
    chk(grant_o && grant_idx_o == 3'd7, "R2 last pending", grant_idx_o, 7);
    pulse_eos();
    chk(level_o == 4'd8, "R9 back to idle", level_o, 8);
    // R10: eos while idle
    pulse_eos(); tick();
    chk(level_o == 4'd8 && !grant_o, "R10 eos idle ignored", level_o, 8);

    // R5 R9: preempt and unwind
    pulse_req(8'b0100_0000); tick();
    chk(level_o == 4'd6, "R3 level 6", level_o, 6);
    pulse_req(8'b0000_1000); tick();
    chk(grant_o && level_o == 4'd3, "R5 preempt", level_o, 3);
    pulse_req(8'b0001_0000); tick(); tick();
    chk(!grant_o && level_o == 4'd3, "R4 withheld", level_o, 3);
    pulse_eos();
    chk(level_o == 4'd6, "R9 restore 6", level_o, 6);
    tick();
    chk(grant_o && grant_idx_o == 3'd4, "R5 pending preempts restored", grant_idx_o, 4);
    pulse_eos();
    chk(level_o == 4'd6, "R9 restore again", level_o, 6);
    pulse_eos();
    chk(level_o == 4'd8, "R9 idle", level_o, 8);

    // R7: mask
    set_mask(8'hFF);
    pulse_req(8'hFF); tick(); tick(); tick();
    chk(!grant_o && level_o == 4'd8, "R7 all masked", level_o, 8);
    set_mask(8'hDF); tick();
    chk(grant_o && grant_idx_o == 3'd5, "R7 unmasked source", grant_idx_o, 5);
    set_mask(8'h00); tick();
    chk(grant_o && grant_idx_o == 3'd0, "R7 kept pending then preempt", grant_idx_o, 0);
    drain();

    // R8: clear vs re-request on the grant edge
    req_i = 8'h02; tick(); tick(); req_i = '0;
    chk(grant_o && grant_idx_o == 3'd1, "R8 grant", grant_idx_o, 1);
    tick();
    chk(!grant_o, "R8 one-cycle pulse", grant_o, 0);
    pulse_eos(); tick();
    chk(grant_o && grant_idx_o == 3'd1, "R8 re-request kept", grant_idx_o, 1);
    pulse_eos(); tick(); tick();
    chk(!grant_o && level_o == 4'd8, "R8 bit cleared", level_o, 8);

    // R9: full nesting 7 down to 0
    for (int i = 7; i >= 0; i--) begin pulse_req(8'(1 << i)); tick(); end
    chk(level_o == 4'd0, "R9 deepest", level_o, 0);
    for (int i = 1; i <= 8; i++) begin
      pulse_eos();
      chk(level_o == 4'(i), "R9 unwind", level_o, i);
    end

    // sweep of all request patterns from idle
    for (int p = 1; p < 256; p++) begin pulse_req(8'(p)); drain(); end

    // sweep of serving level against new request index
    for (int k = 0; k < 8; k++)
      for (int h = 0; h < 8; h++) begin
        pulse_req(8'(1 << k)); tick(); tick();
        pulse_req(8'(1 << h)); tick(); tick();
        drain();
      end

    // pseudo-random mix
    lfsr = 16'hACE1;
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_i = (lfsr[3:0] == 4'd0) ? lfsr[11:4] : 8'h00;
      eos_i = (lfsr[14:12] == 3'd0);
      mask_we_i = lfsr[15] && (lfsr[6:4] == 3'd7);
      mask_i = {lfsr[2:0], lfsr[13:9]} & 8'h5A;
      tick();
    end
    req_i = '0; eos_i = 1'b0; mask_we_i = 1'b0;
    set_mask(8'h00);
    drain();
    finish_run();
  end
endmodule